// File: doc/BRIEF.md
# Narrow-Bus Word Packing Read Sequencer

This block serves one logical read of a 16-bit or 24-bit word from an external device whose data bus is only 8 or 16 bits wide. A single start pulse arrives with a logical address, a logical-width select, a bus-width select, a mask position and a wait-state count. The block then issues the bus reads needed to gather the word, one read strobe per read, and packs the returned bus data into the result. When the word is complete it is presented with a one-cycle done pulse.

The physical address of the first read is the logical address scaled by a power of two that depends on the logical and physical widths. Reads after the first use the next consecutive bus addresses. The scaled address is then cut down to the device's address lines by a programmable mask. For a 24-bit word on an 8-bit bus, the address step is four bytes but only three bytes are read.

Top module: `nbus_rd_seq`

## Requirements
- R1: The first bus read of a sequence goes to the logical address multiplied by a factor: 2 for a 16-bit word on the 8-bit bus, 4 for a 24-bit word on the 8-bit bus, 1 for a 16-bit word on the 16-bit bus, and 2 for a 24-bit word on the 16-bit bus. `wide_word_i`=1 selects a 24-bit word and `wide_bus_i`=1 selects the 16-bit bus.
- R2: The number of bus reads is 2 (16-bit on 8-bit), 3 (24-bit on 8-bit), 1 (16-bit on 16-bit) or 2 (24-bit on 16-bit). Each read after the first uses the bus address one above the previous one, and the address is held steady for the whole read.
- R3: After scaling, address bits at positions at or above `mask_pos_i` are forced to zero. A value of 22 or more keeps all 22 address lines. For example, position 18 keeps only bits 17..0.
- R4: Each bus read holds `bus_rd_o` high for 1 + `waits_i` consecutive cycles, for `waits_i` from 0 to 7.
- R5: `bus_rd_o` is low for exactly one cycle before each bus read of a sequence. This includes the cycle after the start pulse is taken.
- R6: The word is packed most significant part first. On the 8-bit bus, each read supplies `bus_data_i[7:0]`, and the first read supplies the top byte. For a 24-bit word on the 16-bit bus, the first read supplies bits 23..8 and the second read supplies only its bits 15..8, which become bits 7..0.
- R7: A 16-bit word is returned in `word_o[15:0]`, with `word_o[23:16]` equal to zero.
- R8: A start pulse that arrives while a sequence is in progress is ignored. It starts no further reads and does not change the addresses of the running sequence.
- R9: `done_o` is high for exactly one cycle: the cycle right after the last cycle of the last read's strobe. `word_o` is valid in that cycle, and `bus_rd_o` is low during it.
- R10: During and just after reset, `bus_rd_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one logical read |
| laddr_i | input | 24 | Logical word address |
| wide_word_i | input | 1 | 1 = 24-bit word, 0 = 16-bit word |
| wide_bus_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| mask_pos_i | input | 5 | First address bit forced to zero after scaling |
| waits_i | input | 3 | Wait states added to each bus read |
| bus_addr_o | output | 22 | External bus address |
| bus_rd_o | output | 1 | External read strobe, active high |
| bus_data_i | input | 16 | External read data |
| word_o | output | 24 | Assembled word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit logical address, 22 address lines, a 5-bit mask position, a 3-bit wait count and a 16-bit data bus. These values cover all four width pairings, including the three-read/four-byte-stride case. They also allow masks both above and below the line count, and wait counts from 0 up to the maximum of 7. The bench drives a data pattern that depends on the address, so a byte taken from the wrong read or the wrong lane shows up in `word_o`. It also fires a second start in the middle of a sequence to show that the second start is ignored.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_GAP,
      ST_STROBE
   } seq_state_e;

   // log2 of the address stride in bus words for one logical word
   function automatic logic [1:0] stride_shift(input logic wide_word, input logic wide_bus);
      case ({wide_bus, wide_word})
         2'b00:   return 2'd1;   // 16-bit word, 8-bit bus
         2'b01:   return 2'd2;   // 24-bit word, 8-bit bus
         2'b10:   return 2'd0;   // 16-bit word, 16-bit bus
         default: return 2'd1;   // 24-bit word, 16-bit bus
      endcase
   endfunction

   // index of the final bus read (number of reads minus one)
   function automatic logic [1:0] final_index(input logic wide_word, input logic wide_bus);
      case ({wide_bus, wide_word})
         2'b00:   return 2'd1;
         2'b01:   return 2'd2;   // three reads despite a stride of four
         2'b10:   return 2'd0;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/nbus_addr_xlate.sv
module nbus_addr_xlate #(
   parameter int LA_W = 24,
   parameter int PA_W = 22,
   parameter int MP_W = 5,
   parameter int IX_W = 2
) (
   input  logic [LA_W-1:0] laddr_i,
   input  logic [1:0]      shift_i,
   input  logic [IX_W-1:0] idx_i,
   input  logic [MP_W-1:0] mask_pos_i,
   output logic [PA_W-1:0] paddr_o
);

   localparam int FULL_W = LA_W + 3;

   if (FULL_W < PA_W) begin : g_bad_width
      $error("nbus_addr_xlate: scaled address narrower than bus address");
   end
   if ((1 << MP_W) <= PA_W) begin : g_bad_mask
      $error("nbus_addr_xlate: mask position cannot reach all address lines");
   end

   logic [FULL_W-1:0] scaled;
   logic [PA_W-1:0]   keep;
   logic              unused_hi;

   // base is aligned to the stride, so OR adds the read index without carry
   always_comb scaled = ({3'b000, laddr_i} << shift_i) | FULL_W'(idx_i);

   for (genvar b = 0; b < PA_W; b++) begin : g_keep
      assign keep[b] = (mask_pos_i > MP_W'(b));
   end

   assign paddr_o   = scaled[PA_W-1:0] & keep;
   assign unused_hi = ^scaled[FULL_W-1:PA_W];

endmodule

// File: rtl/nbus_wait_ctr.sv
module nbus_wait_ctr #(
   parameter int WT_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [WT_W-1:0] val_i,
   output logic            zero_o
);

   logic [WT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nbus_pack_acc.sv
module nbus_pack_acc #(
   parameter int BUS_W  = 16,
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              take_i,
   input  logic              wide_bus_i,
   input  logic              first_i,
   input  logic [BUS_W-1:0]  din_i,
   output logic [WORD_W-1:0] acc_nxt_o
);

   localparam int BYTE_W = 8;

   if (BUS_W != 2 * BYTE_W) begin : g_bad_bus
      $error("nbus_pack_acc: bus must be two bytes wide");
   end
   if (WORD_W != BUS_W + BYTE_W) begin : g_bad_word
      $error("nbus_pack_acc: word must be one byte wider than the bus");
   end

   logic [WORD_W-1:0] acc_q;
   logic [BYTE_W-1:0] lane;

   // the wide bus shifts in its upper byte after its first full read
   assign lane = wide_bus_i ? din_i[BUS_W-1 -: BYTE_W] : din_i[BYTE_W-1:0];

   always_comb begin
      acc_nxt_o = acc_q;
      if (take_i) begin
         if (wide_bus_i && first_i) acc_nxt_o = WORD_W'(din_i);
         else                       acc_nxt_o = {acc_q[WORD_W-BYTE_W-1:0], lane};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (take_i)  acc_q <= acc_nxt_o;
   end

endmodule

// File: rtl/nbus_rd_seq.sv
module nbus_rd_seq
   import nbus_pkg::*;
#(
   parameter int LA_W   = 24,
   parameter int PA_W   = 22,
   parameter int MP_W   = 5,
   parameter int WT_W   = 3,
   parameter int BUS_W  = 16,
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LA_W-1:0]   laddr_i,
   input  logic              wide_word_i,
   input  logic              wide_bus_i,
   input  logic [MP_W-1:0]   mask_pos_i,
   input  logic [WT_W-1:0]   waits_i,
   output logic [PA_W-1:0]   bus_addr_o,
   output logic              bus_rd_o,
   input  logic [BUS_W-1:0]  bus_data_i,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);

   localparam int IX_W = 2;

   seq_state_e        state_q;
   logic [LA_W-1:0]   laddr_q;
   logic              wide_word_q;
   logic              wide_bus_q;
   logic [MP_W-1:0]   mask_q;
   logic [WT_W-1:0]   waits_q;
   logic [IX_W-1:0]   idx_q;
   logic [PA_W-1:0]   addr_q;
   logic              rd_q;
   logic              done_q;
   logic [WORD_W-1:0] word_q;

   logic              busy;
   logic              accept;
   logic              wait_zero;
   logic              finish;
   logic              last_rd;
   logic [PA_W-1:0]   next_addr;
   logic [WORD_W-1:0] acc_nxt;

   assign busy    = (state_q != ST_IDLE);
   assign accept  = start_i && !busy;
   assign finish  = (state_q == ST_STROBE) && wait_zero;
   assign last_rd = (idx_q == final_index(wide_word_q, wide_bus_q));

   nbus_addr_xlate #(
      .LA_W (LA_W),
      .PA_W (PA_W),
      .MP_W (MP_W),
      .IX_W (IX_W)
   ) i_xlate (
      .laddr_i    (laddr_q),
      .shift_i    (stride_shift(wide_word_q, wide_bus_q)),
      .idx_i      (idx_q),
      .mask_pos_i (mask_q),
      .paddr_o    (next_addr)
   );

   nbus_wait_ctr #(
      .WT_W (WT_W)
   ) i_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (state_q == ST_GAP),
      .val_i  (waits_q),
      .zero_o (wait_zero)
   );

   nbus_pack_acc #(
      .BUS_W  (BUS_W),
      .WORD_W (WORD_W)
   ) i_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (accept),
      .take_i     (finish),
      .wide_bus_i (wide_bus_q),
      .first_i    (idx_q == '0),
      .din_i      (bus_data_i),
      .acc_nxt_o  (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         laddr_q     <= '0;
         wide_word_q <= 1'b0;
         wide_bus_q  <= 1'b0;
         mask_q      <= '0;
         waits_q     <= '0;
         idx_q       <= '0;
         addr_q      <= '0;
         rd_q        <= 1'b0;
         done_q      <= 1'b0;
         word_q      <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  laddr_q     <= laddr_i;
                  wide_word_q <= wide_word_i;
                  wide_bus_q  <= wide_bus_i;
                  mask_q      <= mask_pos_i;
                  waits_q     <= waits_i;
                  idx_q       <= '0;
                  state_q     <= ST_GAP;
               end
            end
            ST_GAP: begin
               addr_q  <= next_addr;
               rd_q    <= 1'b1;
               state_q <= ST_STROBE;
            end
            ST_STROBE: begin
               if (wait_zero) begin
                  rd_q <= 1'b0;
                  if (last_rd) begin
                     word_q  <= acc_nxt;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_GAP;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_addr_o = addr_q;
   assign bus_rd_o   = rd_q;
   assign word_o     = word_q;
   assign done_o     = done_q;

endmodule

// File: rtl/nbus_rd_seq_chk.sv
module nbus_rd_seq_chk #(
   parameter int LA_W = 24,
   parameter int PA_W = 22,
   parameter int MP_W = 5,
   parameter int WT_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            bus_rd_o,
   input logic [PA_W-1:0] bus_addr_o,
   input logic            done_o,
   input logic            busy,
   input logic [LA_W-1:0] cfg_addr,
   input logic [MP_W-1:0] mask_cfg,
   input logic [WT_W-1:0] waits_cfg
);

   logic [WT_W:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (bus_rd_o) run_q <= run_q + 1'b1;
      else               run_q <= '0;
   end

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !bus_rd_o);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_o && $past(bus_rd_o)) |-> $stable(bus_addr_o));

   // R4
   strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_o |-> (run_q <= {1'b0, waits_cfg}));

   // R3
   mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_o && (int'(mask_cfg) < PA_W)) |-> ((bus_addr_o >> mask_cfg) == '0));

   // R8
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> $stable(cfg_addr));

endmodule

bind nbus_rd_seq nbus_rd_seq_chk #(
   .LA_W (LA_W),
   .PA_W (PA_W),
   .MP_W (MP_W),
   .WT_W (WT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .bus_rd_o   (bus_rd_o),
   .bus_addr_o (bus_addr_o),
   .done_o     (done_o),
   .busy       (busy),
   .cfg_addr   (laddr_q),
   .mask_cfg   (mask_q),
   .waits_cfg  (waits_q)
);

// File: tb/test_nbus_rd_seq.sv
module test_nbus_rd_seq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [23:0] laddr_i = '0;
   logic        wide_word_i = 1'b0;
   logic        wide_bus_i = 1'b0;
   logic [4:0]  mask_pos_i = 5'd22;
   logic [2:0]  waits_i = '0;
   logic [21:0] bus_addr_o;
   logic        bus_rd_o;
   logic [15:0] bus_data_i;
   logic [23:0] word_o;
   logic        done_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] dlo(input logic [21:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction
   function automatic logic [7:0] dhi(input logic [21:0] a);
      return a[7:0] + 8'h51;
   endfunction

   assign bus_data_i = {dhi(bus_addr_o), dlo(bus_addr_o)};

   nbus_rd_seq i_nbus_rd_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .laddr_i     (laddr_i),
      .wide_word_i (wide_word_i),
      .wide_bus_i  (wide_bus_i),
      .mask_pos_i  (mask_pos_i),
      .waits_i     (waits_i),
      .bus_addr_o  (bus_addr_o),
      .bus_rd_o    (bus_rd_o),
      .bus_data_i  (bus_data_i),
      .word_o      (word_o),
      .done_o      (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog actual hung expected done");
      summary();
      $finish;
   end

   // one logical read; optional second start in mid-sequence (R8)
   task automatic run_read(input logic [23:0] la, input logic lw, input logic b16,
                           input logic [4:0] mp, input logic [2:0] w,
                           input bit again, input string tag);
      int          n;
      int          factor;
      logic [31:0] full;
      logic [21:0] keep;
      logic [21:0] ea [0:3];
      logic [21:0] sa [0:3];
      int          sl [0:3];
      logic [23:0] ew;
      int          np = 0;
      int          cyc = 1;
      int          done_cyc = -1;
      bit          prev_rd = 1'b0;
      bit          hold_ok = 1'b1;

      factor = b16 ? (lw ? 2 : 1) : (lw ? 4 : 2);
      n      = b16 ? (lw ? 2 : 1) : (lw ? 3 : 2);
      keep   = (mp < 22) ? 22'((32'd1 << mp) - 1) : 22'h3FFFFF;
      for (int k = 0; k < 4; k++) begin
         full  = 32'(la) * 32'(factor) + 32'(k);
         ea[k] = full[21:0] & keep;
         sa[k] = '0;
         sl[k] = 0;
      end
      if (!b16 && !lw)     ew = {8'h00, dlo(ea[0]), dlo(ea[1])};
      else if (!b16)       ew = {dlo(ea[0]), dlo(ea[1]), dlo(ea[2])};
      else if (!lw)        ew = {8'h00, dhi(ea[0]), dlo(ea[0])};
      else                 ew = {dhi(ea[0]), dlo(ea[0]), dhi(ea[1])};

      @(negedge clk);
      laddr_i = la; wide_word_i = lw; wide_bus_i = b16;
      mask_pos_i = mp; waits_i = w; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (cyc < 200) begin
         if (again) begin
            start_i = (cyc == 3);
            laddr_i = (cyc == 3) ? ~la : la;
         end
         if (bus_rd_o) begin
            if (!prev_rd) begin
               if (np < 4) sa[np] = bus_addr_o;
               np++;
            end else if (np <= 4 && bus_addr_o != sa[np-1]) begin
               hold_ok = 1'b0;
            end
            if (np <= 4) sl[np-1]++;
         end
         if (done_o) begin
            done_cyc = cyc;
            break;
         end
         prev_rd = bus_rd_o;
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      laddr_i = la;

      chk(done_cyc > 0, "R9", {tag, " done seen"}, done_cyc, n * (2 + w) + 1);
      chk(np == n, "R2", {tag, " read count"}, np, n);
      chk(hold_ok, "R2", {tag, " address held"}, hold_ok, 1);
      for (int k = 0; k < n && k < 4; k++) begin
         chk(sa[k] == ea[k], (k == 0) ? "R1" : "R2", {tag, " read address"}, sa[k], ea[k]);
         chk(sl[k] == 1 + w, "R4", {tag, " strobe length"}, sl[k], 1 + w);
      end
      chk(done_cyc == n * (2 + w) + 1, "R5", {tag, " done latency"}, done_cyc, n * (2 + w) + 1);
      chk(word_o == ew, "R6", {tag, " word"}, word_o, ew);
      if (!lw) chk(word_o[23:16] == 8'h00, "R7", {tag, " upper byte"}, word_o[23:16], 0);
      chk(!bus_rd_o, "R9", {tag, " strobe low at done"}, bus_rd_o, 0);
      @(negedge clk);
      chk(!done_o, "R9", {tag, " done one cycle"}, done_o, 0);
      if (again) begin
         int extra = 0;
         repeat (20) begin
            if (bus_rd_o || done_o) extra++;
            @(negedge clk);
         end
         chk(extra == 0, "R8", {tag, " no activity after ignored start"}, extra, 0);
      end
   endtask

   task automatic t_reset();
      chk(!bus_rd_o, "R10", "strobe in reset", bus_rd_o, 0);
      chk(!done_o, "R10", "done in reset", done_o, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_rd_o && !done_o, "R10", "outputs after reset", {bus_rd_o, done_o}, 0);
   endtask

   task automatic t_half_on_byte();  // R1 R2 R6 R7
      run_read(24'h400000, 1'b0, 1'b0, 5'd22, 3'd0, 1'b0, "h8_low");
   endtask
   task automatic t_mask18();        // R3
      run_read(24'h40FFFF, 1'b0, 1'b0, 5'd18, 3'd1, 1'b0, "h8_mask18");
   endtask
   task automatic t_three_bytes();   // R1 R2 R4
      run_read(24'h408000, 1'b1, 1'b0, 5'd22, 3'd2, 1'b0, "w8_a");
      run_read(24'h417FFF, 1'b1, 1'b0, 5'd22, 3'd0, 1'b0, "w8_b");
   endtask
   task automatic t_half_on_half();  // R4 maximum waits
      run_read(24'h012345, 1'b0, 1'b1, 5'd22, 3'd7, 1'b0, "h16");
   endtask
   task automatic t_wide_on_half();  // R6 upper byte of second read
      run_read(24'h010000, 1'b1, 1'b1, 5'd22, 3'd1, 1'b0, "w16_a");
      run_read(24'h03FFFF, 1'b1, 1'b1, 5'd18, 3'd0, 1'b0, "w16_mask18");
   endtask
   task automatic t_small_mask();    // R3
      run_read(24'h000123, 1'b0, 1'b0, 5'd4, 3'd0, 1'b0, "h8_mask4");
   endtask
   task automatic t_restart();       // R8
      run_read(24'h2A5A5A, 1'b1, 1'b0, 5'd22, 3'd1, 1'b1, "restart");
   endtask

   initial begin
      t_reset();
      t_half_on_byte();
      t_mask18();
      t_three_bytes();
      t_half_on_half();
      t_wide_on_half();
      t_small_mask();
      t_restart();
      summary();
      $finish;
   end

endmodule